// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Edge Capture

This block is a bank of up to 32 general-purpose pins behind a small 32-bit register interface. Software writes output levels and per-pin directions, reads back synchronised pin levels, and enables interrupt sources pin by pin. Output bits can be changed atomically through dedicated set and clear offsets, so no read-modify-write sequence is needed.

Interrupt detection is fixed when the block is built. One of four trigger modes is chosen: rising edge, falling edge, either edge, or high level. In the edge modes each detected transition latches a pending bit in a capture register. Software clears a pending bit by writing a one to it. In high-level mode the live pin levels drive the interrupt directly. In every mode, one combined interrupt line is raised when any enabled source is active.

Every pin input passes through a two-flop synchroniser before it is used. The register interface uses a single-cycle write strobe and a single-cycle read strobe. Read data is registered.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset, all pins are inputs (`pin_oe` = 0), the output data is 0, the interrupt mask is 0, the capture register is 0, `irq` is low and `rdata` is 0.
- R2: The register decode uses byte offsets, and only address bits [4:2] are decoded. 0x00 is data: a write sets the output data, and a read returns the synchronised pin levels two clocks after a pin change. 0x04 is direction. 0x08 is the interrupt mask. 0x0C is capture. The direction, mask and capture registers read back their values.
- R3: Register bits at or above the pin count `N` read as zero, and writes to them are ignored.
- R4: `pin_oe[i]` equals direction bit i. A 1 in that bit marks an output, a 0 an input. `pin_out` equals the output data register.
- R5: A write to 0x10 sets every output bit where `wdata` is 1. A write to 0x14 clears every output bit where `wdata` is 1. All other output bits keep their values.
- R6: Capture bit i is set by a 0-to-1 transition of synchronised pin i in rising mode, by a 1-to-0 transition in falling mode, and by either transition in both-edges mode. The bit is set three clocks after the pin changes at the input.
- R7: Writing 1 to a capture bit at 0x0C clears that bit. Writing 0 to it leaves it unchanged.
- R8: If an edge on pin i is detected in the same cycle as a write-one-to-clear of capture bit i, the bit stays set.
- R9: In the edge modes, `irq` is high exactly when (capture AND mask) was non-zero one clock earlier.
- R10: In high-level mode, `irq` is high exactly when (synchronised pins AND mask) was non-zero one clock earlier, and the capture register stays zero.
- R11: `rdata` updates only on the clock edge that samples `rd_en`, so it is valid one cycle after the strobe. Reads of 0x10, 0x14 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | N | Asynchronous pin levels |
| pin_out | output | N | Output data to pads |
| pin_oe | output | N | Per-pin output enable (1 = drive) |
| irq | output | 1 | Combined registered interrupt |

## Verification
The assertions check the following on every clock:
- a pending capture bit is never lost unless a one was written to it;
- a detected edge always leaves its bit set, even when a clear arrives in the same cycle;
- an all-zero mask keeps `irq` low;
- set and clear writes touch only the selected output bits;
- `rdata` holds its value between read strobes.

Only the bench scenarios can show the rest:
- which transitions each trigger mode actually captures;
- the two-clock synchroniser latency on readback;
- that high bits are dropped;
- the exact cycle in which a clear collides with a new edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_BOTH = 2'd2,
    TRIG_HIGH = 2'd3
  } trig_e;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 5;

  // word index = byte offset >> 2
  localparam logic [2:0] IDX_DATA = 3'd0;
  localparam logic [2:0] IDX_DIR  = 3'd1;
  localparam logic [2:0] IDX_MASK = 3'd2;
  localparam logic [2:0] IDX_CAP  = 3'd3;
  localparam logic [2:0] IDX_SET  = 3'd4;
  localparam logic [2:0] IDX_CLR  = 3'd5;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge
  import gpio_pkg::*;
#(
  parameter int    N    = 32,
  parameter trig_e TRIG = TRIG_RISE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] cap_o,
  output logic         irq_o
);
  logic [N-1:0] edge_w;
  logic [N-1:0] src_w;
  logic [N-1:0] cap_q;
  logic         irq_q;

  if (TRIG == TRIG_HIGH) begin : g_level
    assign edge_w = '0;
    assign src_w  = lvl_i;
  end else begin : g_edge
    logic [N-1:0] prev_q;
    always_ff @(posedge clk) begin
      if (rst) prev_q <= '0;
      else     prev_q <= lvl_i;
    end
    if (TRIG == TRIG_RISE) begin : g_rise
      assign edge_w = lvl_i & ~prev_q;
    end else if (TRIG == TRIG_FALL) begin : g_fall
      assign edge_w = ~lvl_i & prev_q;
    end else begin : g_both
      assign edge_w = lvl_i ^ prev_q;
    end
    assign src_w = cap_q;
  end

  // a new edge has priority over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) cap_q <= '0;
    else     cap_q <= (cap_q & ~clr_i) | edge_w;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(src_w & mask_i);
  end

  assign cap_o = cap_q;
  assign irq_o = irq_q;

  assert_w1c_hold_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((($past(cap_q) & ~$past(clr_i))) & ~cap_q) == '0));

  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (|edge_w) |=> ((cap_q & $past(edge_w)) == $past(edge_w)));

  assert_mask_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '0) |=> !irq_o);

  if (TRIG == TRIG_HIGH) begin : g_chk_level
    assert_level_irq_R10: assert property (@(posedge clk) disable iff (rst)
      (|(lvl_i & mask_i)) |=> irq_o);
  end else begin : g_chk_edge
    assert_cap_irq_R9: assert property (@(posedge clk) disable iff (rst)
      (|(cap_q & mask_i)) |=> irq_o);
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int N = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       idx_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [N-1:0]     pins_i,
  input  logic [N-1:0]     cap_i,
  output logic [N-1:0]     out_o,
  output logic [N-1:0]     dir_o,
  output logic [N-1:0]     mask_o,
  output logic [N-1:0]     clr_o,
  output logic [BUS_W-1:0] rdata_o
);
  logic [N-1:0]     wbits;
  logic [N-1:0]     out_q, dir_q, mask_q;
  logic [BUS_W-1:0] rdata_q;
  logic             unused_wdata;

  assign wbits        = wdata_i[N-1:0];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      case (idx_i)
        IDX_DATA: out_q  <= wbits;
        IDX_DIR:  dir_q  <= wbits;
        IDX_MASK: mask_q <= wbits;
        IDX_SET:  out_q  <= out_q | wbits;
        IDX_CLR:  out_q  <= out_q & ~wbits;
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_en && idx_i == IDX_CAP) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (idx_i)
        IDX_DATA: rdata_q <= BUS_W'(pins_i);
        IDX_DIR:  rdata_q <= BUS_W'(dir_q);
        IDX_MASK: rdata_q <= BUS_W'(mask_q);
        IDX_CAP:  rdata_q <= BUS_W'(cap_i);
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;

  assert_set_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx_i == IDX_SET) |=>
      ((out_q & $past(wbits)) == $past(wbits)) &&
      ((out_q & ~$past(wbits)) == ($past(out_q) & ~$past(wbits))));

  assert_clr_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx_i == IDX_CLR) |=>
      ((out_q & $past(wbits)) == '0) &&
      ((out_q & ~$past(wbits)) == ($past(out_q) & ~$past(wbits))));

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (idx_i == IDX_DATA || idx_i == IDX_SET || idx_i == IDX_CLR))
      |=> $stable(out_q));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int    N    = 32,
  parameter trig_e TRIG = TRIG_RISE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq
);
  logic [N-1:0] lvl_w, cap_w, clr_w, mask_w;
  logic [2:0]   idx_w;
  logic         unused_addr;

  assign idx_w       = addr[4:2];
  assign unused_addr = ^addr[1:0];

  gpio_sync #(.W(N), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_in),
    .q_o (lvl_w)
  );

  gpio_regs #(.N(N)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .idx_i   (idx_w),
    .wdata_i (wdata),
    .pins_i  (lvl_w),
    .cap_i   (cap_w),
    .out_o   (pin_out),
    .dir_o   (pin_oe),
    .mask_o  (mask_w),
    .clr_o   (clr_w),
    .rdata_o (rdata)
  );

  gpio_edge #(.N(N), .TRIG(TRIG)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (lvl_w),
    .clr_i  (clr_w),
    .mask_i (mask_w),
    .cap_o  (cap_w),
    .irq_o  (irq)
  );
endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  import gpio_pkg::*;
  localparam int NP = 8;
  localparam logic [31:0] LOW = 32'hFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [NP-1:0] pin_in = '0;
  logic [31:0] rd_r, rd_f, rd_b, rd_h;
  logic [NP-1:0] po_r, po_f, po_b, po_h, oe_r, oe_f, oe_b, oe_h;
  logic irq_r, irq_f, irq_b, irq_h;
  logic [31:0] vr, vf, vb, vh;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  gpio_port #(.N(NP), .TRIG(TRIG_RISE)) dut (.clk, .rst, .wr_en, .rd_en, .addr, .wdata,
    .rdata(rd_r), .pin_in, .pin_out(po_r), .pin_oe(oe_r), .irq(irq_r));
  gpio_port #(.N(NP), .TRIG(TRIG_FALL)) dut_fall (.clk, .rst, .wr_en, .rd_en, .addr, .wdata,
    .rdata(rd_f), .pin_in, .pin_out(po_f), .pin_oe(oe_f), .irq(irq_f));
  gpio_port #(.N(NP), .TRIG(TRIG_BOTH)) dut_both (.clk, .rst, .wr_en, .rd_en, .addr, .wdata,
    .rdata(rd_b), .pin_in, .pin_out(po_b), .pin_oe(oe_b), .irq(irq_b));
  gpio_port #(.N(NP), .TRIG(TRIG_HIGH)) dut_high (.clk, .rst, .wr_en, .rd_en, .addr, .wdata,
    .rdata(rd_h), .pin_in, .pin_out(po_h), .pin_oe(oe_h), .irq(irq_h));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    vr = rd_r; vf = rd_f; vb = rd_b; vh = rd_h;
  endtask

  task automatic chk_cap(input string tag, input logic [31:0] er, ef, eb, eh);
    rd(5'h0C);
    chk({tag, " rise"}, vr, er);
    chk({tag, " fall"}, vf, ef);
    chk({tag, " both"}, vb, eb);
    chk({tag, " high"}, vh, eh);
  endtask

  task automatic chk_irq(input string tag, input logic er, ef, eb, eh);
    chk({tag, " rise"}, {31'd0, irq_r}, {31'd0, er});
    chk({tag, " fall"}, {31'd0, irq_f}, {31'd0, ef});
    chk({tag, " both"}, {31'd0, irq_b}, {31'd0, eb});
    chk({tag, " high"}, {31'd0, irq_h}, {31'd0, eh});
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    settle(4);
    rst = 1'b0;
    settle(1);
    // R1 reset state
    chk("R1 pin_oe", 32'(oe_r), 0);
    chk("R1 pin_out", 32'(po_r), 0);
    chk("R1 rdata", rd_r, 0);
    chk_irq("R1 irq", 0, 0, 0, 0);
    rd(5'h04); chk("R1 dir", vr, 0);
    rd(5'h08); chk("R1 mask", vr, 0);
    chk_cap("R1 cap", 0, 0, 0, 0);

    // R3 high bits; R2 readback; R4 oe
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04); chk("R3 dir high bits", vr, LOW);
    chk("R4 pin_oe all", 32'(oe_r), LOW);
    wr(5'h04, 32'h0000_5AA5); rd(5'h04); chk("R2 dir", vr, 32'hA5);
    chk("R4 pin_oe", 32'(oe_r), 32'hA5);
    wr(5'h08, 32'hABCD_003C); rd(5'h08); chk("R2 mask", vr, 32'h3C);
    wr(5'h08, 0);

    // R4 output data sweep
    for (int v = 0; v < 256; v++) begin
      wr(5'h00, 32'hFFFF_FF00 | v);
      chk("R4 pin_out", 32'(po_r), v);
    end

    // R5 atomic set / clear
    for (int k = 0; k < 16; k++) begin
      logic [31:0] s, m, c;
      s = (k * 17) & LOW; m = (k * 37 + 5) & LOW; c = (k * 91 + 3) & LOW;
      wr(5'h00, s);
      wr(5'h10, m | 32'hFF00_0000);
      chk("R5 set", 32'(po_r), s | m);
      wr(5'h14, c);
      chk("R5 clear", 32'(po_r), (s | m) & ~c);
    end

    // R11 read of write-only and unmapped offsets
    rd(5'h10); chk("R11 set reads 0", vr, 0);
    rd(5'h14); chk("R11 clr reads 0", vr, 0);
    rd(5'h1C); chk("R11 unmapped 0", vr, 0);
    wr(5'h04, 0);
    rd(5'h04);
    settle(3); chk("R11 rdata holds", vr, rd_r);

    // R2 pin readback sweep
    for (int v = 0; v < 256; v++) begin
      pin_in = v[NP-1:0];
      settle(2);
      rd(5'h00);
      chk("R2 pin read", vr, v);
    end

    // clear capture registers
    pin_in = '0; settle(4);
    wr(5'h0C, 32'hFFFF_FFFF);
    chk_cap("R7 cleared", 0, 0, 0, 0);

    // R6 / R7 / R10 per-pin edge sweep
    for (int i = 0; i < NP; i++) begin
      logic [31:0] b;
      b = 32'd1 << i;
      pin_in = b[NP-1:0]; settle(4);
      chk_cap("R6 after rise", b, 0, b, 0);
      pin_in = '0; settle(4);
      chk_cap("R6 after fall", b, b, b, 0);
      wr(5'h0C, ~b);
      chk_cap("R7 write zero keeps", b, b, b, 0);
      wr(5'h0C, b);
      chk_cap("R7 write one clears", 0, 0, 0, 0);
    end

    // R9 / R10 interrupt behaviour
    pin_in = 8'h04; settle(4);
    chk_irq("R9 masked off", 0, 0, 0, 0);
    wr(5'h08, 32'h04); settle(1);
    chk_irq("R9 R10 enabled", 1, 0, 1, 1);
    wr(5'h08, 32'h08); settle(1);
    chk_irq("R9 other mask", 0, 0, 0, 0);
    wr(5'h08, 32'h04);
    pin_in = 8'h00; settle(4);
    chk_irq("R10 level drop", 1, 1, 1, 0);
    wr(5'h0C, 32'h04); settle(1);
    chk_irq("R9 after clear", 0, 0, 0, 0);
    wr(5'h08, 0);

    // R8 edge in same cycle as clear
    pin_in = 8'h08; settle(4);
    chk_cap("R8 setup", 32'h08, 0, 32'h08, 0);
    pin_in = 8'h00;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'h0C; wdata = 32'h08;
    @(negedge clk);
    wr_en = 1'b0;
    settle(2);
    chk_cap("R8 edge wins", 0, 32'h08, 32'h08, 0);
    wr(5'h0C, 32'h08);
    chk_cap("R8 later clear", 0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule